// File: doc/BRIEF.md
# Acquisition Board Register Front End

This block sits on a 16-bit I/O bus with a 4-bit byte offset and gives a host access to a multi-channel acquisition board. It holds a 16-bit digital output register, passes the digital input lines through to the bus, and keeps one shared control word. That word packs the channel selects, the enable bit, the converter mode bits and a two-bit analog-output load field.

The block also sequences the analog-to-digital converter. After an enabled channel select, a settle counter raises a ready flag. A write to the sample port starts a conversion of fixed length. When the conversion ends, the sample is captured and a done flag rises. The host then reads the sample as two bytes from one address, high byte first. Analog-output writes are sent to the channel named in the control word, but only while the load field is fully set. Encoder port accesses are decoded and passed through as strobes and bytes.

Top module: `daq_regfront`

## Requirements
- R1: After reset the digital output register reads zero, the control word is 0x0600 (the sample-hold bit 9 and the clock bit 10 are high, all other bits low), both status flags are low, and no strobe output is active.
- R2: A read at offset 0x00 returns the digital input lines. A write at offset 0x00 stores the word, and the debug output shows it one cycle later.
- R3: A write at offset 0x06 replaces the control word. The new value appears on the control output one cycle later.
- R4: Every control write with bit 6 set clears status bit 3. Bit 3 then reads 1 exactly SETTLE_CYC cycles after that write. A control write with bit 6 clear holds bit 3 low.
- R5: A write at offset 0x04 clears status bit 4 and drives a start strobe for one cycle. Bit 4 sets exactly CONV_CYC cycles after the write.
- R6: The 13-bit two's-complement input is captured at completion. Reads at offset 0x04 alternate between two bytes in the low byte of read data: first bits [15:8] of the sample sign-extended to 16 bits, then bits [7:0].
- R7: Every conversion start resets the byte order, so the next read at offset 0x04 returns the high byte again.
- R8: A write at offset 0x02 while control bits [12:11] are both 1 pulses the analog-output load for one cycle. The pulse carries the data bits [11:0] as the code and control bits [2:0] as the channel. With the load field not 2'b11, such a write gives no pulse and leaves the code unchanged.
- R9: A write at offset 0x0C pulses the encoder data strobe, and a write at offset 0x0E pulses the encoder command strobe, each one cycle later and carrying data bits [7:0]. A read at offset 0x0C returns the encoder byte in the low byte and asserts the encoder read strobe during the access.
- R10: Status is read at offset 0x06, with bit 3 as the settle flag, bit 4 as the done flag and all other bits zero. Reading status has no side effect on the byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of bus_rd |
| din | input | 16 | Digital input lines |
| dout | output | 16 | Digital output lines |
| dout_dbg | output | 16 | Debug copy of the digital output register |
| ctrl_out | output | 16 | Current control word |
| adc_start | output | 1 | One-cycle conversion start strobe |
| adc_sample | input | 13 | Converter result, captured at completion |
| dac_load | output | 1 | One-cycle analog-output load strobe |
| dac_chan | output | 3 | Analog-output channel of the last load |
| dac_code | output | 12 | Analog-output code of the last load |
| enc_data_wr | output | 1 | Encoder data write strobe |
| enc_ctrl_wr | output | 1 | Encoder command write strobe |
| enc_wbyte | output | 8 | Byte sent with an encoder strobe |
| enc_rd | output | 1 | Encoder data read strobe |
| enc_byte_in | input | 8 | Byte returned by the encoder |

## Verification
The digital port is tried with several input and output words, including all-ones and single-bit values, so that the read path and the stored path are told apart. The conversion path is run with both a negative and a positive sample. This separates correct sign extension of the high byte from zero-filling, and it checks that the low byte follows the high byte. The settle and conversion flags are sampled one cycle before and at their expected cycle, which catches off-by-one counters. A second conversion started after a single byte read shows that the byte order is reset. Analog-output writes are made with the load field both full and partial, which tells a gated load from an unconditional one.

// File: rtl/daq_pkg.sv
package daq_pkg;
    localparam int BUS_W    = 16;
    localparam int ADDR_W   = 4;
    localparam int SEL_W    = 3;

    localparam logic [ADDR_W-1:0] OFS_DIO  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_AO   = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_AI   = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_ENCD = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_ENCC = 4'hE;

    localparam int CB_AO_LO  = 0;
    localparam int CB_AI_LO  = 3;
    localparam int CB_EN     = 6;
    localparam int CB_SH     = 9;
    localparam int CB_CLK    = 10;
    localparam int CB_LD_LO  = 11;

    localparam int SB_SETTLE = 3;
    localparam int SB_DONE   = 4;

    localparam logic [BUS_W-1:0] CTRL_RESET =
        BUS_W'((1 << CB_SH) | (1 << CB_CLK));
endpackage

// File: rtl/daq_ctl_regs.sv
module daq_ctl_regs
    import daq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dio,
    input  logic             wr_ctl,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] dout_q,
    output logic [BUS_W-1:0] ctrl_q
);
    typedef struct packed {
        logic [BUS_W-1:0] dout;
        logic [BUS_W-1:0] ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_dio) r_d.dout = wdata;
        if (wr_ctl) r_d.ctrl = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.dout <= '0;
            r_q.ctrl <= CTRL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout_q = r_q.dout;
    assign ctrl_q = r_q.ctrl;

    // R2
    dout_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dio |=> $stable(dout_q));

    // R3
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl |=> $stable(ctrl_q));
endmodule

// File: rtl/daq_adc_seq.sv
module daq_adc_seq
    import daq_pkg::*;
#(
    parameter int SETTLE_CYC = 8,
    parameter int CONV_CYC   = 32,
    parameter int SAMPLE_W   = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic                en_new,
    input  logic                en_cur,
    input  logic                conv_start,
    input  logic                rd_sample,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                settled,
    output logic                done,
    output logic                adc_start,
    output logic [7:0]          sample_byte
);
    localparam int SCNT_W = $clog2(SETTLE_CYC + 1);
    localparam int CCNT_W = $clog2(CONV_CYC + 1);
    localparam int PAD_W  = BUS_W - SAMPLE_W;

    typedef struct packed {
        logic [SCNT_W-1:0]   scnt;
        logic [CCNT_W-1:0]   ccnt;
        logic                done;
        logic                hi_sel;
        logic                start;
        logic [SAMPLE_W-1:0] sample;
    } seq_t;

    seq_t s_d, s_q;
    logic [BUS_W-1:0] wide;

    always_comb begin
        s_d       = s_q;
        s_d.start = conv_start;
        if (ctl_wr && en_new) begin
            s_d.scnt = SCNT_W'(SETTLE_CYC);
        end else if (s_q.scnt != '0) begin
            s_d.scnt = s_q.scnt - 1'b1;
        end
        if (conv_start) begin
            s_d.ccnt   = CCNT_W'(CONV_CYC);
            s_d.done   = 1'b0;
            s_d.hi_sel = 1'b1;
        end else begin
            if (s_q.ccnt != '0) begin
                s_d.ccnt = s_q.ccnt - 1'b1;
                if (s_q.ccnt == CCNT_W'(1)) begin
                    s_d.done   = 1'b1;
                    s_d.sample = adc_sample;
                end
            end
            if (rd_sample) s_d.hi_sel = ~s_q.hi_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.hi_sel <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign wide        = {{PAD_W{s_q.sample[SAMPLE_W-1]}}, s_q.sample};
    assign sample_byte = s_q.hi_sel ? wide[15:8] : wide[7:0];
    assign settled     = en_cur && (s_q.scnt == '0);
    assign done        = s_q.done;
    assign adc_start   = s_q.start;

    // R4
    settle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && en_new) |=> !settled);

    // R5
    conv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (!done && adc_start));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !conv_start) |=> done);

    // R7
    hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> s_q.hi_sel);
endmodule

// File: rtl/daq_dac_latch.sv
module daq_dac_latch #(
    parameter int DAC_W = 12,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dac_wr,
    input  logic [1:0]       ld_field,
    input  logic [SEL_W-1:0] chan_sel,
    input  logic [DAC_W-1:0] code_in,
    output logic             load,
    output logic [SEL_W-1:0] chan,
    output logic [DAC_W-1:0] code
);
    typedef struct packed {
        logic             load;
        logic [SEL_W-1:0] chan;
        logic [DAC_W-1:0] code;
    } dac_t;

    dac_t a_d, a_q;
    logic armed;

    assign armed = &ld_field;

    always_comb begin
        a_d      = a_q;
        a_d.load = 1'b0;
        if (dac_wr && armed) begin
            a_d.load = 1'b1;
            a_d.chan = chan_sel;
            a_d.code = code_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign load = a_q.load;
    assign chan = a_q.chan;
    assign code = a_q.code;

    // R8
    dac_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_wr && armed) |=> (!load && $stable(code) && $stable(chan)));
endmodule

// File: rtl/daq_enc_pass.sv
module daq_enc_pass (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_data,
    input  logic       wr_cmd,
    input  logic [7:0] wbyte,
    output logic       data_stb,
    output logic       cmd_stb,
    output logic [7:0] byte_out
);
    typedef struct packed {
        logic       data_stb;
        logic       cmd_stb;
        logic [7:0] b;
    } enc_t;

    enc_t e_d, e_q;

    always_comb begin
        e_d          = e_q;
        e_d.data_stb = wr_data;
        e_d.cmd_stb  = wr_cmd;
        if (wr_data || wr_cmd) e_d.b = wbyte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign data_stb = e_q.data_stb;
    assign cmd_stb  = e_q.cmd_stb;
    assign byte_out = e_q.b;

    // R9
    enc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_stb, cmd_stb}));
endmodule

// File: rtl/daq_regfront.sv
module daq_regfront
    import daq_pkg::*;
#(
    parameter int SETTLE_CYC = 8,
    parameter int CONV_CYC   = 32,
    parameter int SAMPLE_W   = 13,
    parameter int DAC_W      = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [15:0]         bus_wdata,
    output logic [15:0]         bus_rdata,
    input  logic [15:0]         din,
    output logic [15:0]         dout,
    output logic [15:0]         dout_dbg,
    output logic [15:0]         ctrl_out,
    output logic                adc_start,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                dac_load,
    output logic [2:0]          dac_chan,
    output logic [DAC_W-1:0]    dac_code,
    output logic                enc_data_wr,
    output logic                enc_ctrl_wr,
    output logic [7:0]          enc_wbyte,
    output logic                enc_rd,
    input  logic [7:0]          enc_byte_in
);
    logic wr_dio, wr_ao, wr_ai, wr_ctl, wr_encd, wr_encc, rd_ai;
    logic [BUS_W-1:0] dout_q, ctrl_q, status;
    logic settled, done;
    logic [7:0] sample_byte;

    assign wr_dio  = bus_wr && (bus_addr == OFS_DIO);
    assign wr_ao   = bus_wr && (bus_addr == OFS_AO);
    assign wr_ai   = bus_wr && (bus_addr == OFS_AI);
    assign wr_ctl  = bus_wr && (bus_addr == OFS_STAT);
    assign wr_encd = bus_wr && (bus_addr == OFS_ENCD);
    assign wr_encc = bus_wr && (bus_addr == OFS_ENCC);
    assign rd_ai   = bus_rd && (bus_addr == OFS_AI);
    assign enc_rd  = bus_rd && (bus_addr == OFS_ENCD);

    daq_ctl_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_dio (wr_dio),
        .wr_ctl (wr_ctl),
        .wdata  (bus_wdata),
        .dout_q (dout_q),
        .ctrl_q (ctrl_q)
    );

    daq_adc_seq #(
        .SETTLE_CYC (SETTLE_CYC),
        .CONV_CYC   (CONV_CYC),
        .SAMPLE_W   (SAMPLE_W)
    ) u_adc (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (wr_ctl),
        .en_new      (bus_wdata[CB_EN]),
        .en_cur      (ctrl_q[CB_EN]),
        .conv_start  (wr_ai),
        .rd_sample   (rd_ai),
        .adc_sample  (adc_sample),
        .settled     (settled),
        .done        (done),
        .adc_start   (adc_start),
        .sample_byte (sample_byte)
    );

    daq_dac_latch #(
        .DAC_W (DAC_W),
        .SEL_W (SEL_W)
    ) u_dac (
        .clk      (clk),
        .rst_n    (rst_n),
        .dac_wr   (wr_ao),
        .ld_field (ctrl_q[CB_LD_LO +: 2]),
        .chan_sel (ctrl_q[CB_AO_LO +: SEL_W]),
        .code_in  (bus_wdata[DAC_W-1:0]),
        .load     (dac_load),
        .chan     (dac_chan),
        .code     (dac_code)
    );

    daq_enc_pass u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_encd),
        .wr_cmd   (wr_encc),
        .wbyte    (bus_wdata[7:0]),
        .data_stb (enc_data_wr),
        .cmd_stb  (enc_ctrl_wr),
        .byte_out (enc_wbyte)
    );

    always_comb begin
        status            = '0;
        status[SB_SETTLE] = settled;
        status[SB_DONE]   = done;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_DIO:  bus_rdata = din;
            OFS_AI:   bus_rdata = {8'h00, sample_byte};
            OFS_STAT: bus_rdata = status;
            OFS_ENCD: bus_rdata = {8'h00, enc_byte_in};
            default:  bus_rdata = '0;
        endcase
    end

    assign dout     = dout_q;
    assign dout_dbg = dout_q;
    assign ctrl_out = ctrl_q;

    // R8
    dac_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> $past(wr_ao && (ctrl_q[CB_LD_LO +: 2] == 2'b11)));

    // R3
    ctrl_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (ctrl_out == $past(bus_wdata)));
endmodule

// File: tb/daq_regfront_test.sv
module daq_regfront_test;
    localparam int SETTLE = 8;
    localparam int CONV   = 32;

    localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_DIN = 3'd2,
                           K_DBG = 3'd3, K_CTL = 3'd4;
    localparam int NV = 12;
    localparam logic [22:0] VEC [NV] = '{
        {K_DIN, 4'h0, 16'h1234},
        {K_RD,  4'h0, 16'h1234},
        {K_WR,  4'h0, 16'hA5C3},
        {K_DBG, 4'h0, 16'hA5C3},
        {K_DIN, 4'h0, 16'hFFFF},
        {K_RD,  4'h0, 16'hFFFF},
        {K_WR,  4'h0, 16'h0001},
        {K_DBG, 4'h0, 16'h0001},
        {K_WR,  4'h6, 16'h0640},
        {K_CTL, 4'h0, 16'h0640},
        {K_WR,  4'h6, 16'h0600},
        {K_CTL, 4'h0, 16'h0600}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0, bus_rdata, din = '0;
    logic [15:0] dout, dout_dbg, ctrl_out;
    logic adc_start, dac_load, enc_data_wr, enc_ctrl_wr, enc_rd;
    logic [12:0] adc_sample = '0;
    logic [2:0] dac_chan;
    logic [11:0] dac_code;
    logic [7:0] enc_wbyte, enc_byte_in = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    daq_regfront #(.SETTLE_CYC(SETTLE), .CONV_CYC(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .din(din), .dout(dout), .dout_dbg(dout_dbg), .ctrl_out(ctrl_out),
        .adc_start(adc_start), .adc_sample(adc_sample), .dac_load(dac_load),
        .dac_chan(dac_chan), .dac_code(dac_code), .enc_data_wr(enc_data_wr),
        .enc_ctrl_wr(enc_ctrl_wr), .enc_wbyte(enc_wbyte), .enc_rd(enc_rd),
        .enc_byte_in(enc_byte_in)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #0.5 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
    end

    initial begin
        logic [15:0] v;
        logic [22:0] e;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 dout_dbg", dout_dbg, 16'h0000);
        chk("R1 ctrl_out", ctrl_out, 16'h0600);
        peek(4'h6, v);
        chk("R1 status", v, 16'h0000);
        chk("R1 strobes", {11'b0, adc_start, dac_load, enc_data_wr, enc_ctrl_wr, enc_rd}, 16'h0);

        // R2 R3 vector walk
        for (int i = 0; i < NV; i++) begin
            e = VEC[i];
            case (e[22:20])
                K_WR:  bus_write(e[19:16], e[15:0]);
                K_DIN: din = e[15:0];
                K_RD:  begin bus_read(e[19:16], v); chk("R2 din read", v, e[15:0]); end
                K_DBG: begin chk("R2 dout_dbg", dout_dbg, e[15:0]); chk("R2 dout", dout, e[15:0]); end
                K_CTL: chk("R3 ctrl_out", ctrl_out, e[15:0]);
                default: ;
            endcase
        end

        // R4 settle timing, channel 3 enabled
        bus_write(4'h6, 16'h0658);
        peek(4'h6, v);
        chk("R4 settle cleared", v & 16'h0008, 16'h0000);
        idle(SETTLE - 1);
        peek(4'h6, v);
        chk("R4 settle early", v & 16'h0008, 16'h0000);
        idle(1);
        peek(4'h6, v);
        chk("R4 settle set", v & 16'h0008, 16'h0008);
        bus_write(4'h6, 16'h0618);
        idle(SETTLE + 2);
        peek(4'h6, v);
        chk("R4 disabled low", v & 16'h0008, 16'h0000);

        // R5 R6 negative sample
        adc_sample = 13'h1ABC;
        bus_write(4'h4, 16'h0000);
        chk("R5 start pulse", {15'b0, adc_start}, 16'h1);
        peek(4'h6, v);
        chk("R5 done cleared", v & 16'h0010, 16'h0000);
        idle(1);
        chk("R5 start single", {15'b0, adc_start}, 16'h0);
        idle(CONV - 2);
        peek(4'h6, v);
        chk("R5 done early", v & 16'h0010, 16'h0000);
        idle(1);
        peek(4'h6, v);
        chk("R5 done set", v, 16'h0010);
        adc_sample = 13'h0000;
        // R10 status read does not toggle byte order
        peek(4'h6, v);
        bus_read(4'h4, v);
        chk("R6 high byte neg", v, 16'h00FA);
        bus_read(4'h4, v);
        chk("R6 low byte neg", v, 16'h00BC);
        bus_read(4'h4, v);
        chk("R6 high again", v, 16'h00FA);

        // R7 positive sample, restart after one byte read leaves order at low
        adc_sample = 13'h0123;
        bus_write(4'h4, 16'h0000);
        idle(CONV);
        bus_read(4'h4, v);
        chk("R7 high after restart", v, 16'h0001);
        bus_read(4'h4, v);
        chk("R6 low byte pos", v, 16'h0023);

        // R8 gated analog output
        bus_write(4'h6, 16'h1E05);
        bus_write(4'h2, 16'hFABC);
        chk("R8 load pulse", {15'b0, dac_load}, 16'h1);
        chk("R8 chan", {13'b0, dac_chan}, 16'h5);
        chk("R8 code", {4'b0, dac_code}, 16'h0ABC);
        idle(1);
        chk("R8 load single", {15'b0, dac_load}, 16'h0);
        bus_write(4'h6, 16'h0E02);
        bus_write(4'h2, 16'h0123);
        chk("R8 no load partial", {15'b0, dac_load}, 16'h0);
        chk("R8 code kept", {4'b0, dac_code}, 16'h0ABC);
        chk("R8 chan kept", {13'b0, dac_chan}, 16'h5);

        // R9 encoder pass-through
        bus_write(4'hE, 16'h1201);
        chk("R9 cmd strobe", {14'b0, enc_ctrl_wr, enc_data_wr}, 16'h2);
        chk("R9 cmd byte", {8'b0, enc_wbyte}, 16'h0001);
        bus_write(4'hC, 16'h3455);
        chk("R9 data strobe", {14'b0, enc_ctrl_wr, enc_data_wr}, 16'h1);
        chk("R9 data byte", {8'b0, enc_wbyte}, 16'h0055);
        enc_byte_in = 8'h3C;
        @(negedge clk);
        bus_addr = 4'hC; bus_rd = 1'b1;
        #1;
        chk("R9 enc read", bus_rdata, 16'h003C);
        chk("R9 enc rd strobe", {15'b0, enc_rd}, 16'h1);
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        chk("R9 enc rd idle", {15'b0, enc_rd}, 16'h0);

        // R10 unused offset reads zero
        bus_read(4'hA, v);
        chk("R10 unused offset", v, 16'h0000);

        summary();
    end
endmodule